// File: doc/BRIEF.md
# Receive Descriptor Scatter Writer

This block takes one incoming frame at a time and scatters it into a ring of receive buffer descriptors held in a shared memory. Each descriptor is two 32-bit words at an 8-byte stride. The first word holds a 16-bit flag field (upper half) and a 16-bit length field (lower half). The second word holds the byte address of the data buffer. The block appends a 4-byte CRC-32 to the stored data. It fills each buffer up to a programmable maximum, writes back the length and status, and marks the final descriptor with a last flag and error flags. It can optionally prefix two zero bytes so that the payload starts on an aligned boundary.

The block tracks a receive-active state. A ring-load pulse points the block at the ring start and clears the active state. An arm pulse makes the block read the current descriptor and become active if that descriptor is empty. A frame start carries the payload length. The payload bytes are then pulled one per cycle through a ready handshake. After each frame the block reads the next descriptor and stays active only if that descriptor is empty. The memory port is 32 bits wide with byte enables. A read returns its data on the cycle after the request.

Top module: `rxsg_writer`

## Requirements
- R1: The stored size S is the payload length plus 4, plus 2 more when `shift_en` is high at frame start. A descriptor's length field (bits 15:0 of its first word) records the bytes placed in its buffer.
- R2: If the full size exceeds `trunc_lim`, S is clipped to `trunc_lim` and both the truncation flag (flag bit 0) and the length-error flag (flag bit 5) are set on the final descriptor.
- R3: If S exceeds `user_lim` without truncation, only the length-error flag (flag bit 5) is set.
- R4: Each buffer receives at most `max_buf & 0x3FF0` bytes. A buffer is filled completely before the next descriptor is used.
- R5: The last 4 stored bytes are the Ethernet CRC-32 of the payload, most significant byte first. They may be split across two consecutive buffers.
- R6: In shift mode only the first buffer of a frame starts with two zero bytes; the first payload byte follows them.
- R7: Every used descriptor has its empty flag (flag bit 15) cleared, with other flag bits kept. The final one also gets the last flag (flag bit 11) plus error flags and pulses `evt_rxf`. Every other one pulses `evt_rxb`.
- R8: After a descriptor, the pointer advances by 8, or returns to `ring_base` when that descriptor's wrap flag (flag bit 13) is set.
- R9: If a descriptor with the empty flag clear is reached in mid-frame, no further bytes are written and the rest of the payload is still consumed from the source.
- R10: After a frame, `rx_active` equals the empty flag of the next descriptor. `arm` while inactive sets `rx_active` from the empty flag of the current descriptor.
- R11: A `frm_start` while `rx_active` is low pulses `evt_reject`, consumes no bytes and touches no memory.
- R12: After reset, `rx_active`, `busy` and every memory request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Byte address of the first descriptor in the ring |
| max_buf | input | 16 | Maximum buffer fill, masked to 0x3FF0, nonzero |
| user_lim | input | 16 | Size above which the length-error flag is set |
| trunc_lim | input | 16 | Hard size limit (at least 8) |
| shift_en | input | 1 | Prefix two zero bytes to the frame |
| ring_load | input | 1 | Load the pointer from `ring_base`, clear active (idle only) |
| arm | input | 1 | Peek the current descriptor when inactive (idle only) |
| frm_start | input | 1 | Frame start, sampled when idle |
| frm_len | input | 16 | Payload byte count, valid with `frm_start` |
| frm_data | input | 8 | Payload byte, valid whenever `frm_ready` is high |
| frm_ready | output | 1 | A payload byte is taken at this edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| rx_active | output | 1 | Receive-active state |
| busy | output | 1 | A frame or peek is in progress |
| evt_rxf | output | 1 | Pulse: final descriptor of a frame written back |
| evt_rxb | output | 1 | Pulse: intermediate descriptor written back |
| evt_reject | output | 1 | Pulse: frame refused while inactive |

## Verification
A buffer boundary can fall inside the 4-byte CRC tail, so the byte written in one cycle is CRC data while the write-back of that same descriptor must already give the shortened length. Frames are sized so that one to three CRC bytes spill into the next buffer. The bench then compares the whole memory image and the spilled bytes with a descriptor-level model. A second case is truncation: there the drain of the clipped payload into the CRC must end before the first CRC byte is written. The bench checks this with small truncation limits against the same model.

// File: rtl/rxsg_pkg.sv
// Shared definitions for the receive scatter writer.
// Assumes descriptors of two 32-bit words; flags in the upper half of word 0.
package rxsg_pkg;
    localparam int LEN_W      = 16;
    localparam int DESC_BYTES = 8;
    localparam int FLG_EMPTY  = 15;
    localparam int FLG_WRAP   = 13;
    localparam int FLG_LAST   = 11;
    localparam int FLG_LONG   = 5;
    localparam int FLG_TRUNC  = 0;
    localparam logic [LEN_W-1:0] BUF_MASK = 16'h3FF0;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PEEK, ST_PEEKW, ST_D0, ST_D1, ST_D2,
        ST_WR, ST_CRCD, ST_WB, ST_DROP
    } rxsg_state_e;
endpackage

// File: rtl/rxsg_crc32.sv
// Byte-serial CRC-32 (reflected polynomial, all-ones preset, inverted output).
// Assumes one byte per enabled cycle; clr has priority over en.
module rxsg_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    logic [31:0] st, nxt;

    // Fold one byte into the running remainder, bit by bit.
    always_comb begin
        nxt = st ^ {24'h0, din};
        for (int b = 0; b < 8; b++) begin
            nxt = nxt[0] ? ((nxt >> 1) ^ 32'hEDB8_8320) : (nxt >> 1);
        end
    end

    // Hold the remainder; preset on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) st <= '1;
        else if (en)       st <= nxt;
    end

    assign crc = ~st;
endmodule

// File: rtl/rxsg_sizer.sv
// Computes the stored frame size and the two oversize flags at frame start.
// Assumes trunc_lim of at least 8 so the CRC and prefix always fit.
module rxsg_sizer import rxsg_pkg::*; (
    input  logic [LEN_W-1:0] len,
    input  logic             shift,
    input  logic [LEN_W-1:0] trunc_lim,
    input  logic [LEN_W-1:0] user_lim,
    output logic [LEN_W-1:0] size,
    output logic             err_tr,
    output logic             err_lg
);
    logic [LEN_W:0] full;

    // Clip against the hard limit, then flag against the user limit.
    always_comb begin
        full   = {1'b0, len} + (LEN_W+1)'(4) + (shift ? (LEN_W+1)'(2) : '0);
        err_tr = full > {1'b0, trunc_lim};
        size   = err_tr ? trunc_lim : full[LEN_W-1:0];
        err_lg = err_tr || (size > user_lim);
    end
endmodule

// File: rtl/rxsg_bytesel.sv
// Picks the byte for the current stored position: CRC tail, zero prefix or payload.
// Assumes remain counts stored bytes still to write, including this one.
module rxsg_bytesel import rxsg_pkg::*; (
    input  logic [LEN_W-1:0] remain,
    input  logic [1:0]       zero_left,
    input  logic [31:0]      crc,
    input  logic [7:0]       pay,
    output logic [7:0]       byte_o,
    output logic             in_crc,
    output logic             in_zero,
    output logic             need_pay
);
    // Classify the position and select its byte, CRC most significant byte first.
    always_comb begin
        in_crc   = remain <= LEN_W'(4);
        in_zero  = !in_crc && (zero_left != 2'd0);
        need_pay = !in_crc && !in_zero;
        if (in_crc) begin
            case (remain[2:0])
                3'd4:    byte_o = crc[31:24];
                3'd3:    byte_o = crc[23:16];
                3'd2:    byte_o = crc[15:8];
                default: byte_o = crc[7:0];
            endcase
        end else if (in_zero) begin
            byte_o = 8'h00;
        end else begin
            byte_o = pay;
        end
    end
endmodule

// File: rtl/rxsg_writer.sv
// Receive scatter writer: reads descriptors, writes frame bytes one per cycle
// with byte enables, writes back length and flags, then peeks the next descriptor.
// Assumes a memory that always grants and returns read data one cycle later,
// a nonzero masked max_buf, and a source that supplies a byte whenever frm_ready.
module rxsg_writer import rxsg_pkg::*; #(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_base,
    input  logic [LEN_W-1:0] max_buf,
    input  logic [LEN_W-1:0] user_lim,
    input  logic [LEN_W-1:0] trunc_lim,
    input  logic             shift_en,
    input  logic             ring_load,
    input  logic             arm,
    input  logic             frm_start,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [7:0]       frm_data,
    output logic             frm_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             rx_active,
    output logic             busy,
    output logic             evt_rxf,
    output logic             evt_rxb,
    output logic             evt_reject
);
    rxsg_state_e      state;
    logic [AW-1:0]    ptr, baddr, wa;
    logic [15:0]      dflags, newflags;
    logic [LEN_W-1:0] remain, blen, bcnt, pay_left, mb, sz;
    logic [1:0]       zero_left;
    logic             err_tr, err_lg, sz_tr, sz_lg;
    logic             sel_crc, sel_zero, sel_pay, accept, crc_clr, last;
    logic [7:0]       sel_byte;
    logic [31:0]      crc;

    rxsg_sizer u_sizer (
        .len(frm_len), .shift(shift_en), .trunc_lim(trunc_lim), .user_lim(user_lim),
        .size(sz), .err_tr(sz_tr), .err_lg(sz_lg)
    );

    rxsg_bytesel u_sel (
        .remain(remain), .zero_left(zero_left), .crc(crc), .pay(frm_data),
        .byte_o(sel_byte), .in_crc(sel_crc), .in_zero(sel_zero), .need_pay(sel_pay)
    );

    rxsg_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(frm_ready), .din(frm_data), .crc(crc)
    );

    // Derived control terms.
    assign mb      = max_buf & BUF_MASK;
    assign wa      = baddr + AW'(bcnt);
    assign accept  = (state == ST_IDLE) && !ring_load && frm_start;
    assign crc_clr = accept && rx_active;
    assign last    = remain == '0;
    assign busy    = state != ST_IDLE;

    // Final flags: empty cleared, last and errors added on the final descriptor.
    always_comb begin
        newflags = dflags;
        newflags[FLG_EMPTY] = 1'b0;
        if (last) begin
            newflags[FLG_LAST]  = 1'b1;
            newflags[FLG_LONG]  = dflags[FLG_LONG] | err_lg;
            newflags[FLG_TRUNC] = dflags[FLG_TRUNC] | err_tr;
        end
    end

    // Payload pull, event pulses.
    assign frm_ready  = ((state == ST_WR) && sel_pay) || (state == ST_CRCD) ||
                        ((state == ST_DROP) && (pay_left != '0));
    assign evt_rxf    = (state == ST_WB) && last;
    assign evt_rxb    = (state == ST_WB) && !last;
    assign evt_reject = accept && !rx_active;

    // Memory port driven from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_be    = 4'h0;
        mem_wdata = 32'h0;
        case (state)
            ST_PEEK, ST_D0: mem_req = 1'b1;
            ST_D1: begin
                mem_req  = mem_rdata[16+FLG_EMPTY];
                mem_addr = ptr + AW'(4);
            end
            ST_WR: begin
                if (!(sel_crc && pay_left != '0)) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {wa[AW-1:2], 2'b00};
                    mem_be    = 4'b0001 << wa[1:0];
                    mem_wdata = {4{sel_byte}};
                end
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = {newflags, blen};
            end
            default: ;
        endcase
    end

    // Sequencer: descriptor fetch, byte fill, write-back, drain and peek.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; ptr <= '0; baddr <= '0; dflags <= '0;
            remain <= '0; blen <= '0; bcnt <= '0; pay_left <= '0;
            zero_left <= '0; err_tr <= 1'b0; err_lg <= 1'b0; rx_active <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ring_load) begin
                        ptr       <= ring_base;
                        rx_active <= 1'b0;
                    end else if (frm_start) begin
                        if (rx_active) begin
                            remain    <= sz;
                            pay_left  <= frm_len;
                            zero_left <= shift_en ? 2'd2 : 2'd0;
                            err_tr    <= sz_tr;
                            err_lg    <= sz_lg;
                            state     <= ST_D0;
                        end
                    end else if (arm && !rx_active) begin
                        state <= ST_PEEK;
                    end
                end
                ST_PEEK:  state <= ST_PEEKW;
                ST_PEEKW: begin
                    rx_active <= mem_rdata[16+FLG_EMPTY];
                    state     <= ST_IDLE;
                end
                ST_D0: state <= ST_D1;
                ST_D1: begin
                    if (mem_rdata[16+FLG_EMPTY]) begin
                        dflags <= mem_rdata[31:16];
                        state  <= ST_D2;
                    end else begin
                        state <= ST_DROP;
                    end
                end
                ST_D2: begin
                    baddr <= mem_rdata[AW-1:0];
                    blen  <= (remain < mb) ? remain : mb;
                    bcnt  <= '0;
                    state <= ST_WR;
                end
                ST_WR: begin
                    if (sel_crc && pay_left != '0) begin
                        state <= ST_CRCD;
                    end else begin
                        bcnt   <= bcnt + 1'b1;
                        remain <= remain - 1'b1;
                        if (sel_zero) zero_left <= zero_left - 2'd1;
                        if (sel_pay)  pay_left  <= pay_left - 1'b1;
                        if (bcnt == blen - 1'b1) state <= ST_WB;
                    end
                end
                ST_CRCD: begin
                    pay_left <= pay_left - 1'b1;
                    if (pay_left == LEN_W'(1)) state <= ST_WR;
                end
                ST_WB: begin
                    ptr   <= dflags[FLG_WRAP] ? ring_base : ptr + AW'(DESC_BYTES);
                    state <= last ? ST_DROP : ST_D0;
                end
                ST_DROP: begin
                    if (pay_left != '0) pay_left <= pay_left - 1'b1;
                    else                state    <= ST_PEEK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12: no memory write is issued while idle.
    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    // R4: data writes touch exactly one byte lane.
    a_r4_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

    // R7: each descriptor event coincides with a full-word write-back.
    a_r7_event_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rxf || evt_rxb) |-> (mem_we && mem_be == 4'hF));

    // R9: payload is pulled only inside a frame.
    a_r9_pull_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> busy);

    // R10: receive-active rises only at the end of a peek.
    a_r10_rise_after_peek: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> $past(busy));

    // R11: a rejected frame leaves the block idle.
    a_r11_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reject |=> !busy);
endmodule

// File: tb/test_rxsg_writer.sv
module test_rxsg_writer;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [31:0] ring_base = 32'h0;
    logic [15:0] max_buf = 16'd64, user_lim = 16'd2000, trunc_lim = 16'd2000;
    logic        shift_en = 1'b0, ring_load = 1'b0, arm = 1'b0, frm_start = 1'b0;
    logic [15:0] frm_len = '0;
    logic [7:0]  frm_data = '0;
    logic        frm_ready, mem_req, mem_we, rx_active, busy, evt_rxf, evt_rxb, evt_reject;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    rxsg_writer #(.AW(32)) i_rxsg_writer (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_buf(max_buf),
        .user_lim(user_lim), .trunc_lim(trunc_lim), .shift_en(shift_en),
        .ring_load(ring_load), .arm(arm), .frm_start(frm_start), .frm_len(frm_len),
        .frm_data(frm_data), .frm_ready(frm_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_active(rx_active), .busy(busy), .evt_rxf(evt_rxf), .evt_rxb(evt_rxb),
        .evt_reject(evt_reject)
    );

    always #4 clk = ~clk;

    localparam int NDESC = 6;
    logic [31:0] mem  [0:1023];
    logic [31:0] emem [0:1023];
    logic [7:0]  pay  [0:511];
    logic [7:0]  str  [0:2047];
    int checks = 0, fails = 0, cycles = 0;
    int n_rxf = 0, n_rxb = 0, n_rej = 0;
    int exp_ptr = 0, exp_rxf = 0, exp_rxb = 0, exp_rej = 0;
    bit exp_active = 0;
    bit prime_go = 0;
    int prime_hole = -1;
    int consumed;

    // Memory model with the primer for descriptor flags.
    always @(posedge clk) begin
        if (prime_go) begin
            for (int i = 0; i < NDESC; i++) begin
                mem[2*i] <= (i == prime_hole) ? 32'h0 :
                            (32'h8000_0000 | ((i == NDESC-1) ? 32'h2000_0000 : 32'h0));
                mem[2*i+1] <= 32'h400 + i*32'h80;
            end
        end else if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    // Event monitors sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_rxf)    n_rxf++;
            if (evt_rxb)    n_rxb++;
            if (evt_reject) n_rej++;
        end
    end

    // Watchdog: a hung run is one failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] crc32(int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, pay[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] mbyte(int a);
        return mem[a >> 2][8*(a & 3) +: 8];
    endfunction

    task automatic eset(int a, logic [7:0] v);
        emem[a >> 2][8*(a & 3) +: 8] = v;
    endtask

    task automatic prime(int hole);
        for (int i = 0; i < NDESC; i++) begin
            emem[2*i] = (i == hole) ? 32'h0 :
                        (32'h8000_0000 | ((i == NDESC-1) ? 32'h2000_0000 : 32'h0));
            emem[2*i+1] = 32'h400 + i*32'h80;
        end
        prime_hole = hole;
        @(negedge clk) prime_go = 1;
        @(negedge clk) prime_go = 0;
    endtask

    task automatic do_arm();
        @(negedge clk) arm = 1;
        @(negedge clk) arm = 0;
        repeat (3) @(negedge clk);
        if (!exp_active) exp_active = emem[exp_ptr >> 2][31];
    endtask

    // Descriptor-level expectation of one frame (R1..R10).
    task automatic model_frame(int len, int mb, bit sh, int ul, int tl);
        int full, s, k, p, ba, bl;
        bit tr, lg;
        logic [31:0] c, w0;
        logic [15:0] nf;
        if (!exp_active) begin exp_rej++; return; end
        full = len + 4 + (sh ? 2 : 0);
        tr = full > tl;
        s = tr ? tl : full;
        lg = tr || (s > ul);
        c = crc32(len);
        for (int j = 0; j < s; j++) begin
            if (j >= s - 4)        str[j] = c[8*(3 - (j - (s - 4))) +: 8];
            else if (sh && j < 2)  str[j] = 8'h00;
            else                   str[j] = pay[j - (sh ? 2 : 0)];
        end
        k = 0; p = exp_ptr;
        while (k < s) begin
            w0 = emem[p >> 2];
            if (!w0[31]) break;
            ba = emem[(p + 4) >> 2];
            bl = (s - k < mb) ? s - k : mb;
            for (int j = 0; j < bl; j++) eset(ba + j, str[k + j]);
            k += bl;
            nf = w0[31:16] & 16'h7FFF;
            if (k == s) begin
                nf = nf | 16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0);
                exp_rxf++;
            end else begin
                exp_rxb++;
            end
            emem[p >> 2] = {nf, 16'(bl)};
            p = w0[29] ? 0 : p + 8;
        end
        exp_ptr = p;
        exp_active = emem[p >> 2][31];
    endtask

    task automatic send(int len);
        int guard = 0;
        consumed = 0;
        @(negedge clk) begin frm_start = 1; frm_len = 16'(len); frm_data = pay[0]; end
        @(negedge clk) frm_start = 0;
        while (busy && guard < 5000) begin
            frm_data = (consumed < len) ? pay[consumed] : 8'h00;
            if (frm_ready) consumed++;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_frame(int len, int mb, bit sh, int ul, int tl, int hole);
        int mism = 0;
        bit act0;
        for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
        @(negedge clk) begin max_buf = 16'(mb); shift_en = sh; user_lim = 16'(ul); trunc_lim = 16'(tl); end
        prime(hole);
        do_arm();
        act0 = exp_active;
        model_frame(len, mb, sh, ul, tl);
        send(len);
        for (int w = 0; w < 1024; w++) if (mem[w] !== emem[w]) mism++;
        check("R1 R2 R3 R4 R5 R6 R7 R8 memory image words differing", mism, 0);
        check("R9 payload bytes consumed", consumed, act0 ? len : 0);
        check("R10 rx_active after frame", {31'h0, rx_active}, {31'h0, exp_active});
        check("R7 final-event count", n_rxf, exp_rxf);
        check("R7 buffer-event count", n_rxb, exp_rxb);
        check("R11 reject count", n_rej, exp_rej);
    endtask

    initial begin
        int hole;
        logic [31:0] c;
        int lens[4];
        void'($urandom(32'd20240611));
        for (int w = 0; w < 1024; w++) begin mem[w] = 32'h0; emem[w] = 32'h0; end
        repeat (3) @(negedge clk);
        check("R12 reset rx_active", {31'h0, rx_active}, 32'h0);
        check("R12 reset busy", {31'h0, busy}, 32'h0);
        check("R12 reset mem_req", {31'h0, mem_req}, 32'h0);
        @(negedge clk) rst_n = 1;
        @(negedge clk) ring_load = 1;
        @(negedge clk) ring_load = 0;
        check("R12 idle after reset release", {31'h0, rx_active}, 32'h0);

        // R11: frame while inactive, no arm.
        for (int i = 0; i < 40; i++) pay[i] = 8'(i);
        prime(-1);
        model_frame(40, 64, 0, 2000, 2000);
        send(40);
        check("R11 reject event", n_rej, 1);
        check("R11 no bytes taken", consumed, 0);
        check("R11 memory untouched", mem[0], emem[0]);

        // R10: arm makes the block active.
        do_arm();
        check("R10 arm sets rx_active", {31'h0, rx_active}, 32'h1);

        // R5: CRC spills 2 bytes into the second buffer (desc0, desc1).
        do_frame(30, 32, 0, 2000, 2000, -1);
        c = crc32(30);
        check("R5 CRC byte 2 at start of second buffer", {24'h0, mbyte(32'h480)}, {24'h0, c[15:8]});
        check("R5 CRC byte 0 at tail of first buffer", {24'h0, mbyte(32'h41E)}, {24'h0, c[31:24]});
        check("R4 second descriptor length", {16'h0, mem[2][15:0]}, 32'd2);
        check("R4 first descriptor length", {16'h0, mem[0][15:0]}, 32'd32);

        // R6 and R1: shift prefix in a single buffer (desc2).
        do_frame(50, 64, 1, 2000, 2000, -1);
        check("R6 first zero byte", {24'h0, mbyte(32'h500)}, 32'h0);
        check("R6 second zero byte", {24'h0, mbyte(32'h501)}, 32'h0);
        check("R6 payload after prefix", {24'h0, mbyte(32'h502)}, {24'h0, pay[0]});
        check("R1 stored size with prefix", {16'h0, mem[4][15:0]}, 32'd56);

        // R2: truncation (desc3).
        do_frame(100, 112, 0, 2000, 64, -1);
        check("R2 truncated length", {16'h0, mem[6][15:0]}, 32'd64);
        check("R2 flags last+long+trunc", {16'h0, mem[6][31:16]}, 32'h0821);

        // R3: user limit only (desc4).
        do_frame(60, 112, 0, 50, 2000, -1);
        check("R3 flags last+long", {16'h0, mem[8][31:16]}, 32'h0820);

        // R9 and R8: start at desc5 (wrap flag), wrap to desc0, desc1 not empty.
        do_frame(150, 32, 0, 2000, 2000, 1);
        check("R8 wrap reached first descriptor", {16'h0, mem[0][15:0]}, 32'd32);
        check("R9 no final event on dropped frame", n_rxf, exp_rxf);
        check("R10 inactive after drop", {31'h0, rx_active}, 32'h0);

        // Random mix including spills of 1..3 CRC bytes and small hard limits.
        lens[0] = 32; lens[1] = 48; lens[2] = 64; lens[3] = 112;
        for (int f = 0; f < 20; f++) begin
            hole = ($urandom % 5 == 0) ? int'($urandom % NDESC) : -1;
            do_frame(8 + int'($urandom % 200), lens[$urandom % 4], 1'($urandom % 2),
                     30 + int'($urandom % 240), ($urandom % 4 == 0) ? 70 : 2000, hole);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule